// File: doc/BRIEF.md
# Timer and External Interrupt Control Register

This block is an 8-bit control and status register for a microcontroller core. It holds the run enables for two timers, latches each timer's overflow as a pending interrupt flag, and watches two active-low external interrupt pins. Each pin can be set to either falling-edge or low-level sensing. Software updates the register with whole-byte writes or with writes to a single indexed bit. The CPU reads the register back as one byte. It also returns one acknowledge strobe per interrupt source when it vectors to that source's handler.

In edge mode, an external flag latches and the CPU's acknowledge clears it. In level mode, the external flag is the inverted, synchronized pin and nothing else. Timer flags always latch. The bit positions are fixed because software decodes them. The register sits at address 0x88 of the special-function space and is bit addressable, but address decode happens outside this block.

Top module: `tic_ctrl_reg`

## Requirements
- R1: While reset is asserted, and after it is released with no other stimulus, the read value is 0x00 and every run and pending output is 0. The external pins idle high, meaning inactive.
- R2: The read value has this layout: bit 7 is the timer-1 flag, bit 6 is the timer-1 run bit, bit 5 is the timer-0 flag and bit 4 is the timer-0 run bit. Bit 3 is the external-1 flag, bit 2 is the external-1 type, bit 1 is the external-0 flag and bit 0 is the external-0 type. Each flag bit shows the same value as its pending output.
- R3: A byte write loads all eight bits on the next clock edge. A single-bit write loads only the bit selected by the 3-bit index. When both occur in the same cycle, the byte write wins and the single-bit write is dropped.
- R4: The run outputs equal the run bits and change only on a write.
- R5: A timer overflow pulse sets that timer's flag on the next edge. A write of 0 to the flag clears it, and so does that timer's acknowledge strobe. A write of 1 sets it.
- R6: When an overflow pulse falls in the same cycle as a write of 0 or an acknowledge for that timer, the flag ends up set.
- R7: In edge mode (type bit 1), a falling edge on the pin sets the flag three clock edges after the pin changes: two synchronizer stages plus the latch. The acknowledge strobe or a write of 0 clears it, and a write of 1 sets it. A rising edge, or a pin held low, does not set the flag.
- R8: In level mode (type bit 0), the flag equals the inverse of the pin, delayed by two synchronizer edges. Acknowledge strobes and writes to the flag bit do not change it.
- R9: In edge mode, a detected falling edge that coincides with that channel's acknowledge leaves the flag set.
- R10: While a channel is in level mode, any latched edge flag is discarded, so switching back to edge mode starts with the flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_byte_en | input | 1 | Whole-register write strobe |
| wr_byte_data | input | 8 | Data for a whole-register write |
| wr_bit_en | input | 1 | Single-bit write strobe |
| wr_bit_idx | input | 3 | Bit index for a single-bit write |
| wr_bit_val | input | 1 | Value for a single-bit write |
| rd_data | output | 8 | Current register value |
| t0_ovf | input | 1 | Timer-0 overflow pulse |
| t1_ovf | input | 1 | Timer-1 overflow pulse |
| xpin0_n | input | 1 | External interrupt pin 0, active low, asynchronous |
| xpin1_n | input | 1 | External interrupt pin 1, active low, asynchronous |
| ack_t0 | input | 1 | CPU vector acknowledge for timer 0 |
| ack_t1 | input | 1 | CPU vector acknowledge for timer 1 |
| ack_x0 | input | 1 | CPU vector acknowledge for external 0 |
| ack_x1 | input | 1 | CPU vector acknowledge for external 1 |
| run0 | output | 1 | Timer-0 run enable |
| run1 | output | 1 | Timer-1 run enable |
| pend_t0 | output | 1 | Timer-0 pending flag |
| pend_t1 | output | 1 | Timer-1 pending flag |
| pend_x0 | output | 1 | External-0 pending flag |
| pend_x1 | output | 1 | External-1 pending flag |

## Verification
Two functions can land on the same edge: the hardware setting of a flag, from an overflow pulse or a detected falling edge, and the clearing of that flag by software or by the CPU's acknowledge. Directed cases place an overflow pulse, an acknowledge and a write of 0 in one cycle. They also time an external acknowledge to the exact edge on which the synchronized falling edge is latched. Both cases are judged by the flag being set afterwards. A long random phase then mixes writes, pulses, acknowledges and pin toggles, and compares every output each cycle against a behavioural model that resolves these collisions in favour of the set.

// File: rtl/tic_pkg.sv
package tic_pkg;
   localparam int unsigned REG_W      = 8;
   localparam int unsigned IDX_W      = $clog2(REG_W);
   localparam int unsigned BIT_X0_TYP = 0;
   localparam int unsigned BIT_X0_FLG = 1;
   localparam int unsigned BIT_X1_TYP = 2;
   localparam int unsigned BIT_X1_FLG = 3;
   localparam int unsigned BIT_T0_RUN = 4;
   localparam int unsigned BIT_T0_FLG = 5;
   localparam int unsigned BIT_T1_RUN = 6;
   localparam int unsigned BIT_T1_FLG = 7;
endpackage

// File: rtl/tic_sync.sv
module tic_sync #(
   parameter int unsigned STAGES  = 2,
   parameter bit          RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("tic_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL}};
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/tic_flag.sv
module tic_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic set_i,
   input  logic ack_i,
   input  logic wr_i,
   input  logic wr_val_i,
   output logic flag_o
);
   logic flag_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      flag_q <= 1'b0;
      else if (!en_i)  flag_q <= 1'b0;
      else if (set_i)  flag_q <= 1'b1;
      else if (wr_i)   flag_q <= wr_val_i;
      else if (ack_i)  flag_q <= 1'b0;
   end

   assign flag_o = flag_q;

   // R6
   hw_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && set_i) |=> flag_o);

   // R5
   ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && !set_i && !wr_i && ack_i) |=> !flag_o);

   // R10
   disabled_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> !flag_o);
endmodule

// File: rtl/tic_ext_chan.sv
module tic_ext_chan #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_n_i,
   input  logic edge_mode_i,
   input  logic ack_i,
   input  logic wr_i,
   input  logic wr_val_i,
   output logic pend_o
);
   logic pin_s;
   logic pin_prev_q;
   logic fall;
   logic lat;

   tic_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pin_n_i),
      .q_o   (pin_s)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) pin_prev_q <= 1'b1;
      else        pin_prev_q <= pin_s;
   end

   assign fall = pin_prev_q & ~pin_s;

   tic_flag u_flag (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_i     (edge_mode_i),
      .set_i    (fall),
      .ack_i    (ack_i),
      .wr_i     (wr_i),
      .wr_val_i (wr_val_i),
      .flag_o   (lat)
   );

   assign pend_o = edge_mode_i ? lat : ~pin_s;

   // R7
   edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode_i && $fell(pin_s) && $past(rst_n)) |=> lat);
endmodule

// File: rtl/tic_ctrl_reg.sv
module tic_ctrl_reg
   import tic_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_byte_en,
   input  logic [REG_W-1:0] wr_byte_data,
   input  logic             wr_bit_en,
   input  logic [IDX_W-1:0] wr_bit_idx,
   input  logic             wr_bit_val,
   output logic [REG_W-1:0] rd_data,
   input  logic             t0_ovf,
   input  logic             t1_ovf,
   input  logic             xpin0_n,
   input  logic             xpin1_n,
   input  logic             ack_t0,
   input  logic             ack_t1,
   input  logic             ack_x0,
   input  logic             ack_x1,
   output logic             run0,
   output logic             run1,
   output logic             pend_t0,
   output logic             pend_t1,
   output logic             pend_x0,
   output logic             pend_x1
);
   localparam int unsigned N_CH = 2;

   generate
      if (REG_W != 4 * N_CH) begin : g_bad_layout
         $error("tic_ctrl_reg: layout needs four bits per channel pair");
      end
   endgenerate

   logic [REG_W-1:0] wr_en;
   logic [REG_W-1:0] wr_val;

   always_comb begin
      for (int i = 0; i < REG_W; i++) begin
         wr_en[i]  = wr_byte_en | (wr_bit_en & (wr_bit_idx == IDX_W'(i)));
         wr_val[i] = wr_byte_en ? wr_byte_data[i] : wr_bit_val;
      end
   end

   logic [N_CH-1:0] run_q, typ_q;
   logic [N_CH-1:0] tmr_set, tmr_ack, tmr_pend;
   logic [N_CH-1:0] ext_pin, ext_ack, ext_pend;
   logic [N_CH-1:0] run_we, run_wv, typ_we, typ_wv;
   logic [N_CH-1:0] tf_we, tf_wv, xf_we, xf_wv;

   assign tmr_set = {t1_ovf, t0_ovf};
   assign tmr_ack = {ack_t1, ack_t0};
   assign ext_pin = {xpin1_n, xpin0_n};
   assign ext_ack = {ack_x1, ack_x0};

   assign run_we = {wr_en[BIT_T1_RUN],  wr_en[BIT_T0_RUN]};
   assign run_wv = {wr_val[BIT_T1_RUN], wr_val[BIT_T0_RUN]};
   assign typ_we = {wr_en[BIT_X1_TYP],  wr_en[BIT_X0_TYP]};
   assign typ_wv = {wr_val[BIT_X1_TYP], wr_val[BIT_X0_TYP]};
   assign tf_we  = {wr_en[BIT_T1_FLG],  wr_en[BIT_T0_FLG]};
   assign tf_wv  = {wr_val[BIT_T1_FLG], wr_val[BIT_T0_FLG]};
   assign xf_we  = {wr_en[BIT_X1_FLG],  wr_en[BIT_X0_FLG]};
   assign xf_wv  = {wr_val[BIT_X1_FLG], wr_val[BIT_X0_FLG]};

   genvar c;
   generate
      for (c = 0; c < N_CH; c++) begin : g_ch
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               run_q[c] <= 1'b0;
               typ_q[c] <= 1'b0;
            end else begin
               if (run_we[c]) run_q[c] <= run_wv[c];
               if (typ_we[c]) typ_q[c] <= typ_wv[c];
            end
         end

         tic_flag u_tflag (
            .clk      (clk),
            .rst_n    (rst_n),
            .en_i     (1'b1),
            .set_i    (tmr_set[c]),
            .ack_i    (tmr_ack[c]),
            .wr_i     (tf_we[c]),
            .wr_val_i (tf_wv[c]),
            .flag_o   (tmr_pend[c])
         );

         tic_ext_chan #(.SYNC_STAGES(SYNC_STAGES)) u_ext (
            .clk         (clk),
            .rst_n       (rst_n),
            .pin_n_i     (ext_pin[c]),
            .edge_mode_i (typ_q[c]),
            .ack_i       (ext_ack[c]),
            .wr_i        (xf_we[c]),
            .wr_val_i    (xf_wv[c]),
            .pend_o      (ext_pend[c])
         );
      end
   endgenerate

   always_comb begin
      rd_data             = '0;
      rd_data[BIT_T1_FLG] = tmr_pend[1];
      rd_data[BIT_T1_RUN] = run_q[1];
      rd_data[BIT_T0_FLG] = tmr_pend[0];
      rd_data[BIT_T0_RUN] = run_q[0];
      rd_data[BIT_X1_FLG] = ext_pend[1];
      rd_data[BIT_X1_TYP] = typ_q[1];
      rd_data[BIT_X0_FLG] = ext_pend[0];
      rd_data[BIT_X0_TYP] = typ_q[0];
   end

   assign run0    = run_q[0];
   assign run1    = run_q[1];
   assign pend_t0 = tmr_pend[0];
   assign pend_t1 = tmr_pend[1];
   assign pend_x0 = ext_pend[0];
   assign pend_x1 = ext_pend[1];

   // R4
   run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_byte_en && !wr_bit_en && $past(rst_n)) |=> $stable({run1, run0}));

   // R3
   byte_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_byte_en && !t0_ovf && !t1_ovf) |=>
         (rd_data[BIT_T1_RUN] == $past(wr_byte_data[BIT_T1_RUN]) &&
          rd_data[BIT_T0_FLG] == $past(wr_byte_data[BIT_T0_FLG])));
endmodule

// File: tb/tic_ctrl_reg_tb.sv
module tic_ctrl_reg_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_byte_en = 1'b0;
   logic [7:0] wr_byte_data = '0;
   logic       wr_bit_en = 1'b0;
   logic [2:0] wr_bit_idx = '0;
   logic       wr_bit_val = 1'b0;
   logic [7:0] rd_data;
   logic       t0_ovf = 1'b0, t1_ovf = 1'b0;
   logic       xpin0_n = 1'b1, xpin1_n = 1'b1;
   logic       ack_t0 = 1'b0, ack_t1 = 1'b0, ack_x0 = 1'b0, ack_x1 = 1'b0;
   logic       run0, run1, pend_t0, pend_t1, pend_x0, pend_x1;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   tic_ctrl_reg u_dut (
      .clk(clk), .rst_n(rst_n),
      .wr_byte_en(wr_byte_en), .wr_byte_data(wr_byte_data),
      .wr_bit_en(wr_bit_en), .wr_bit_idx(wr_bit_idx), .wr_bit_val(wr_bit_val),
      .rd_data(rd_data),
      .t0_ovf(t0_ovf), .t1_ovf(t1_ovf),
      .xpin0_n(xpin0_n), .xpin1_n(xpin1_n),
      .ack_t0(ack_t0), .ack_t1(ack_t1), .ack_x0(ack_x0), .ack_x1(ack_x1),
      .run0(run0), .run1(run1),
      .pend_t0(pend_t0), .pend_t1(pend_t1), .pend_x0(pend_x0), .pend_x1(pend_x1)
   );

   // Behavioural reference: state as a byte, pin history as queues
   logic [7:0] m;
   int hist0[$];
   int hist1[$];

   function automatic bit we_of(int b);
      return wr_byte_en || (wr_bit_en && int'(wr_bit_idx) == b);
   endfunction
   function automatic bit wv_of(int b);
      return wr_byte_en ? wr_byte_data[b] : wr_bit_val;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m = 8'h00;
         hist0 = '{1, 1, 1};
         hist1 = '{1, 1, 1};
      end else begin
         logic [7:0] n;
         bit f0, f1;
         f0 = (hist0[2] == 1) && (hist0[1] == 0);
         f1 = (hist1[2] == 1) && (hist1[1] == 0);
         n = m;
         n[7] = t1_ovf || (we_of(7) ? wv_of(7) : (m[7] && !ack_t1));
         n[5] = t0_ovf || (we_of(5) ? wv_of(5) : (m[5] && !ack_t0));
         for (int b = 0; b < 8; b += 2) if (we_of(b)) n[b] = wv_of(b);
         n[6] = we_of(6) ? wv_of(6) : m[6];
         n[4] = we_of(4) ? wv_of(4) : m[4];
         n[3] = m[2] ? (f1 || (we_of(3) ? wv_of(3) : (m[3] && !ack_x1))) : 1'b0;
         n[1] = m[0] ? (f0 || (we_of(1) ? wv_of(1) : (m[1] && !ack_x0))) : 1'b0;
         m = n;
         hist0.push_front(int'(xpin0_n)); void'(hist0.pop_back());
         hist1.push_front(int'(xpin1_n)); void'(hist1.pop_back());
      end
   end

   function automatic logic [7:0] exp_rd();
      logic [7:0] e;
      e = m;
      e[3] = m[2] ? m[3] : (hist1[1] == 0);
      e[1] = m[0] ? m[1] : (hist0[1] == 0);
      return e;
   endfunction

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // Per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic [7:0] e;
         e = exp_rd();
         chk("R2 read layout", rd_data, e);
         chk("R4 run outputs", {6'b0, run1, run0}, {6'b0, e[6], e[4]});
         chk("R5 timer flags", {6'b0, pend_t1, pend_t0}, {6'b0, e[7], e[5]});
         chk(m[0] ? "R7 ext0 edge flag" : "R8 ext0 level flag", {7'b0, pend_x0}, {7'b0, e[1]});
         chk(m[2] ? "R7 ext1 edge flag" : "R8 ext1 level flag", {7'b0, pend_x1}, {7'b0, e[3]});
      end
   end

   task automatic step(input int n = 1);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic idle();
      wr_byte_en = 0; wr_bit_en = 0;
      t0_ovf = 0; t1_ovf = 0;
      ack_t0 = 0; ack_t1 = 0; ack_x0 = 0; ack_x1 = 0;
   endtask

   task automatic bitw(input int idx, input bit v);
      wr_bit_en = 1; wr_bit_idx = 3'(idx); wr_bit_val = v;
   endtask

   initial begin
      step(3);
      // R1: reset value
      chk("R1 reset value", rd_data, 8'h00);
      chk("R1 reset outputs", {2'b0, run1, run0, pend_t1, pend_t0, pend_x1, pend_x0}, 8'h00);
      rst_n = 1;
      step(1);
      chk("R1 after release", rd_data, 8'h00);

      // R3: byte write beats same-cycle bit write
      wr_byte_en = 1; wr_byte_data = 8'h55; bitw(0, 0);
      step(1); idle();
      chk("R3 byte priority", rd_data, 8'h55);
      bitw(6, 0); step(1); idle();
      chk("R3 single bit write", rd_data, 8'h15);

      // R6: overflow with ack and clear in the same cycle
      t0_ovf = 1; ack_t0 = 1; bitw(5, 0);
      step(1); idle();
      chk("R6 set beats clear", {7'b0, pend_t0}, 8'h01);
      ack_t0 = 1; step(1); idle();
      chk("R5 ack clears", {7'b0, pend_t0}, 8'h00);

      // R9: ext0 in edge mode, ack on the latching edge
      xpin0_n = 0;
      step(2);
      ack_x0 = 1;
      step(1); idle();
      chk("R9 edge set beats ack", {7'b0, pend_x0}, 8'h01);
      xpin0_n = 1;
      step(3);
      chk("R7 rising edge no set hold", {7'b0, pend_x0}, 8'h01);

      // R10: level mode discards the latched flag
      bitw(0, 0); step(1);
      bitw(0, 1); step(1); idle();
      chk("R10 latch discarded", {7'b0, pend_x0}, 8'h00);

      // R8: level mode ignores ack and writes
      bitw(0, 0); step(1); idle();
      xpin0_n = 0; step(3);
      chk("R8 level follows pin", {7'b0, pend_x0}, 8'h01);
      ack_x0 = 1; bitw(1, 0); step(1); idle();
      chk("R8 ack and write ignored", {7'b0, pend_x0}, 8'h01);
      xpin0_n = 1; step(3);
      chk("R8 level released", {7'b0, pend_x0}, 8'h00);

      // Random mixed phase, judged by the per-cycle model compare
      for (int k = 0; k < 4000; k++) begin
         wr_byte_en   = ($urandom_range(0, 9) == 0);
         wr_byte_data = 8'($urandom);
         wr_bit_en    = ($urandom_range(0, 6) == 0);
         wr_bit_idx   = 3'($urandom);
         wr_bit_val   = 1'($urandom);
         t0_ovf = ($urandom_range(0, 9) == 0);
         t1_ovf = ($urandom_range(0, 9) == 0);
         ack_t0 = ($urandom_range(0, 6) == 0);
         ack_t1 = ($urandom_range(0, 6) == 0);
         ack_x0 = ($urandom_range(0, 6) == 0);
         ack_x1 = ($urandom_range(0, 6) == 0);
         if ($urandom_range(0, 7) == 0) xpin0_n = ~xpin0_n;
         if ($urandom_range(0, 7) == 0) xpin1_n = ~xpin1_n;
         step(1);
      end
      idle();
      step(2);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         done = 1;
         checks++; fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule